// File: doc/BRIEF.md
# Channel Event Flag Register with Fast Clear

This block holds one sticky event flag for each of eight timer channels. A one-cycle event pulse on a channel sets that channel's flag. Software clears flags in one of two ways. It can write the register with a one in each bit to clear, or, when fast-clear mode is on, it can touch the channel's 16-bit data register. The channel data registers sit in a contiguous 16-byte window, two bytes per channel. The address decoder outside this block turns an access there into a per-channel strobe.

Each channel is configured as either a capture channel or a compare channel. On a capture channel, a read of its data register is what clears the flag. On a compare channel, a write of its data register does. An access of the other type leaves the flag alone.

An interrupt request is raised while any flag is set whose bit is also set in an external enable mask. The flags can be read at any time, and reading them has no side effect.

Top module: `chan_evt_flags`

## Requirements
- R1: After reset every flag is 0 and the interrupt request is low.
- R2: An event pulse on channel n sets flag n (bit n of the flag vector) at the next clock edge.
- R3: A register write clears each flag whose data bit is 1, and leaves each flag whose data bit is 0 unchanged.
- R4: With fast clear on, a capture-read strobe on a channel configured as capture (mode bit 0) clears that flag at the next edge.
- R5: With fast clear on, a compare-write strobe on a channel configured as compare (mode bit 1) clears that flag at the next edge.
- R6: A strobe of the wrong type for the channel's mode has no effect. That means a capture read on a compare channel, or a compare write on a capture channel.
- R7: With fast clear off, capture-read and compare-write strobes have no effect on any flag.
- R8: An event arriving in the same cycle as any clear leaves the flag set.
- R9: The interrupt request is high exactly when the AND of the flags and the enable mask is nonzero, in the same cycle.
- R10: With no event and no clear, every flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_i | input | 8 | Per-channel event pulses |
| wr_en_i | input | 1 | Flag register write strobe |
| wr_data_i | input | 8 | Write data; ones clear flags |
| fast_clr_en_i | input | 1 | Fast-clear mode enable |
| is_cmp_i | input | 8 | Channel mode: 1 compare, 0 capture |
| cap_rd_i | input | 8 | Per-channel data-register read strobes |
| cmp_wr_i | input | 8 | Per-channel data-register write strobes |
| irq_mask_i | input | 8 | Interrupt enable per channel |
| flags_o | output | 8 | Current flags |
| irq_o | output | 1 | Interrupt request |

## Verification
Directed cases isolate each clear path:
- register writes with mixed one and zero bits;
- capture reads and compare writes, each against the matching and the mismatched channel mode;
- the same accesses with fast clear off;
- events colliding with each clear source.

Together these separate the clear paths from one another and pin down set-over-clear priority. Random cycles then mix all strobes, modes and masks at once. This exposes any channel cross-talk or mixed-up mode decoding against a bench model of the next flag value.

// File: rtl/chan_flag_pkg.sv
package chan_flag_pkg;
    localparam int NUM_CH = 8;

    typedef struct packed {
        logic [NUM_CH-1:0] flags;
    } flag_state_t;
endpackage

// File: rtl/chan_flag_clr.sv
module chan_flag_clr #(
    parameter int N = 8
) (
    input  logic         wr_en_i,
    input  logic [N-1:0] wr_data_i,
    input  logic         fast_clr_en_i,
    input  logic [N-1:0] is_cmp_i,
    input  logic [N-1:0] cap_rd_i,
    input  logic [N-1:0] cmp_wr_i,
    output logic [N-1:0] clr_o
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        logic acc_hit;
        // access type chosen by channel mode
        assign acc_hit = is_cmp_i[g] ? cmp_wr_i[g] : cap_rd_i[g];
        assign clr_o[g] = (wr_en_i & wr_data_i[g]) | (fast_clr_en_i & acc_hit);
    end
endmodule

// File: rtl/chan_flag_irq.sv
module chan_flag_irq #(
    parameter int N = 8
) (
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] mask_i,
    output logic         irq_o
);
    assign irq_o = |(flags_i & mask_i);
endmodule

// File: rtl/chan_evt_flags.sv
module chan_evt_flags
    import chan_flag_pkg::*;
#(
    parameter int N = NUM_CH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         wr_en_i,
    input  logic [N-1:0] wr_data_i,
    input  logic         fast_clr_en_i,
    input  logic [N-1:0] is_cmp_i,
    input  logic [N-1:0] cap_rd_i,
    input  logic [N-1:0] cmp_wr_i,
    input  logic [N-1:0] irq_mask_i,
    output logic [N-1:0] flags_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] flags;
    } state_t;

    state_t       st_d, st_q;
    logic [N-1:0] clr;

    chan_flag_clr #(.N(N)) u_clr (
        .wr_en_i      (wr_en_i),
        .wr_data_i    (wr_data_i),
        .fast_clr_en_i(fast_clr_en_i),
        .is_cmp_i     (is_cmp_i),
        .cap_rd_i     (cap_rd_i),
        .cmp_wr_i     (cmp_wr_i),
        .clr_o        (clr)
    );

    always_comb begin
        st_d = st_q;
        // events win over clears
        st_d.flags = (st_q.flags & ~clr) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    chan_flag_irq #(.N(N)) u_irq (
        .flags_i(st_q.flags),
        .mask_i (irq_mask_i),
        .irq_o  (irq_o)
    );
endmodule

// File: rtl/chan_evt_flags_chk.sv
module chan_evt_flags_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] evt_i,
    input logic         wr_en_i,
    input logic [N-1:0] wr_data_i,
    input logic         fast_clr_en_i,
    input logic [N-1:0] is_cmp_i,
    input logic [N-1:0] cap_rd_i,
    input logic [N-1:0] cmp_wr_i,
    input logic [N-1:0] irq_mask_i,
    input logic [N-1:0] flags_o,
    input logic         irq_o
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_reset_r1: assert property (@(posedge clk) !rst_n |-> (flags_o == '0));

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((flags_o & $past(evt_i)) == $past(evt_i)));

    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en_i)) |->
            ((flags_o & $past(wr_data_i) & ~$past(evt_i)) == '0));

    p_fast_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(fast_clr_en_i)) |->
            ((flags_o & $past(cap_rd_i) & ~$past(is_cmp_i) & ~$past(evt_i)) == '0));

    p_fast_cmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(fast_clr_en_i)) |->
            ((flags_o & $past(cmp_wr_i) & $past(is_cmp_i) & ~$past(evt_i)) == '0));

    p_no_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(fast_clr_en_i) && !$past(wr_en_i)) |->
            ((~flags_o & $past(flags_o)) == '0));

    p_irq_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o & irq_mask_i) == '0) |-> !irq_o);

    p_irq_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o & irq_mask_i) != '0) |-> irq_o);

    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((flags_o & ~$past(flags_o) & ~$past(evt_i)) == '0));
endmodule

bind chan_evt_flags chan_evt_flags_chk #(.N(N)) u_chk (.*);

// File: tb/chan_evt_flags_bench.sv
module chan_evt_flags_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_i = '0, wr_data_i = '0, is_cmp_i = '0;
    logic [N-1:0] cap_rd_i = '0, cmp_wr_i = '0, irq_mask_i = '0;
    logic         wr_en_i = 1'b0, fast_clr_en_i = 1'b0;
    logic [N-1:0] flags_o;
    logic         irq_o;

    int errors = 0;
    int checks = 0;
    logic [N-1:0] model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_evt_flags u_chan_evt_flags (.*);

    function automatic logic [N-1:0] next_flags(
        logic [N-1:0] f, logic [N-1:0] ev, logic we, logic [N-1:0] wd,
        logic fe, logic [N-1:0] cm, logic [N-1:0] rd, logic [N-1:0] cw);
        logic [N-1:0] c;
        c = (we ? wd : '0) | (fe ? ((cm & cw) | (~cm & rd)) : '0);
        return (f & ~c) | ev;
    endfunction

    task automatic check(string tag);
        checks++;
        if (flags_o !== model) begin
            errors++;
            $display("FAIL %s flags actual=%02h expected=%02h", tag, flags_o, model);
        end
        checks++;
        if (irq_o !== (|(model & irq_mask_i))) begin
            errors++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq_o, |(model & irq_mask_i));
        end
    endtask

    // inputs driven at negedge; one clock; model updated; sample at next negedge
    task automatic step(string tag);
        @(posedge clk);
        model = next_flags(model, evt_i, wr_en_i, wr_data_i, fast_clr_en_i,
                           is_cmp_i, cap_rd_i, cmp_wr_i);
        @(negedge clk);
        evt_i = '0; wr_en_i = 1'b0; wr_data_i = '0; cap_rd_i = '0; cmp_wr_i = '0;
        check(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        irq_mask_i = 8'hFF;
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        evt_i = 8'hA5; step("R2 set");
        step("R10 hold");
        wr_en_i = 1'b1; wr_data_i = 8'h81; step("R3 w1c");
        is_cmp_i = 8'hF0; fast_clr_en_i = 1'b1;
        cap_rd_i = 8'h04; step("R4 capture read");
        evt_i = 8'h30; step("R2 set compare");
        cmp_wr_i = 8'h20; step("R5 compare write");
        cmp_wr_i = 8'h01; cap_rd_i = 8'h10; step("R6 wrong type");
        fast_clr_en_i = 1'b0;
        cap_rd_i = 8'h01; cmp_wr_i = 8'h10; step("R7 fast off");
        fast_clr_en_i = 1'b1;
        evt_i = 8'h11; wr_en_i = 1'b1; wr_data_i = 8'h01; cmp_wr_i = 8'h10; step("R8 collision");
        irq_mask_i = 8'h00; @(negedge clk); check("R9 masked");
        irq_mask_i = model; @(negedge clk); check("R9 enabled");
        irq_mask_i = ~model; @(negedge clk); check("R9 disjoint");

        for (int i = 0; i < 400; i++) begin
            evt_i = 8'($urandom) & 8'($urandom) & 8'($urandom);
            wr_en_i = 1'($urandom);
            wr_data_i = 8'($urandom);
            fast_clr_en_i = 1'($urandom);
            is_cmp_i = 8'($urandom);
            cap_rd_i = 8'($urandom);
            cmp_wr_i = 8'($urandom);
            irq_mask_i = 8'($urandom);
            step("R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule